// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block sits behind the command decoder of a serial flash memory. It holds the protection settings and the write enable latch, and it decides whether each destructive request is permitted. The protection settings are a pin-enable bit and a two-bit protection level. The destructive requests are byte program, sector erase, whole-array erase and status write. The decoder sends single-cycle strobes for set-latch, clear-latch and status-load, with the new status byte, and signals the completion of each internal write cycle. It also presents the request kind and the target address. When the frame closes, the decoder pulses `frame_end`, and the unit registers a grant together with the set of sectors the granted operation may touch.

The status byte for a read-status command is produced combinationally. The unit also watches the active-low lock pin: while the pin-enable bit is set, the pin freezes the status register. A falling edge on the pin during an open status-write frame cancels that write.

The array is split into `NSEC` equal sectors addressed by the top address bits. The protection level locks nothing, the top quarter, the top half or the whole array. The non-volatile bits come out of reset at a parameter value.

Top module: `wp_status_unit`

## Requirements
- R1: When idle, the status byte is {pin_en, 3'b000, prot_lvl[1], prot_lvl[0], wel, 1'b0}: bit 7 is the pin-enable bit, bits 3:2 are the protection level, bit 1 is the write enable latch, and bits 6:4 and bit 0 read 0.
- R2: While `wr_busy` is high, the status byte reads 8'hFF.
- R3: After reset, the latch is clear and the stored bits equal `RESET_SR`. `set_wel` sets the latch. A request closed with the latch clear is never granted.
- R4: `clr_wel` clears the latch whatever the level of the lock pin, and `cycle_done` always clears it.
- R5: Program (kind 0) and sector erase (kind 1) are granted only outside the locked range. The sector index is the top log2(NSEC) address bits. Level 01 locks the top quarter of the sectors, level 10 the top half, and level 11 all of them. On a grant, `grant_sel` is one-hot on the addressed sector.
- R6: Whole-array erase (kind 2) is granted unless level 11 is set, and `grant_sel` then marks exactly the unlocked sectors.
- R7: A status write (kind 3) is denied while the lock pin is low and the pin-enable bit is 1. With the pin high or the pin-enable bit at 0, it is granted, given the latch.
- R8: A granted status write changes only bits 7, 3 and 2, taken from the loaded byte. The other data bits are ignored.
- R9: With the pin-enable bit at 1, a falling edge on `lock_pin_n` after `sr_load` and before `frame_end` cancels the status write, even if the pin is high again at frame end.
- R10: While `wr_busy` is high, `set_wel`, `clr_wel` and `sr_load` have no effect and no request is granted.
- R11: `grant` and `grant_sel` are valid for one cycle, the cycle after `frame_end`. The status bits update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_wel | input | 1 | Strobe: set write enable latch |
| clr_wel | input | 1 | Strobe: clear write enable latch |
| sr_load | input | 1 | Strobe: status write data received |
| sr_data | input | 8 | Status write data byte |
| cycle_done | input | 1 | Strobe: internal write cycle finished |
| wr_busy | input | 1 | Internal write cycle in progress |
| lock_pin_n | input | 1 | Active-low hardware lock pin |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 array erase, 3 status write |
| req_addr | input | ADDR_W | Target byte address |
| frame_end | input | 1 | Strobe: select released, register decision |
| allow | output | 1 | Combinational permit for the present request |
| grant | output | 1 | Registered permit pulse |
| grant_sel | output | NSEC | Sectors the granted operation may touch |
| status_byte | output | 8 | Read-status value |

## Verification
A corrupted latch shows on bit 1 of the status byte in the cycle after the strobe. Corrupted protection bits show on bits 7 and 3:2 in the cycle after a granted frame end. A wrong lock mask surfaces only when a request is closed: `grant` or `grant_sel` is then wrong one cycle after `frame_end`. For that reason the directed tests close requests on both sides of every range boundary. A cancel flag that is lost or sticks is visible only through the next status-write grant and the status bits that follow it.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    typedef enum logic [1:0] {
        REQ_PROG = 2'd0,
        REQ_SECT = 2'd1,
        REQ_CHIP = 2'd2,
        REQ_STAT = 2'd3
    } req_kind_e;

    localparam int SR_PIN_EN_BIT = 7;
    localparam int SR_LVL_HI_BIT = 3;
    localparam int SR_LVL_LO_BIT = 2;
    localparam int SR_WEL_BIT    = 1;
endpackage

// File: rtl/wpu_sector_lock.sv
module wpu_sector_lock #(
    parameter int ADDR_W = 17,
    parameter int NSEC   = 4
) (
    input  logic [1:0]        prot_lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEC-1:0]   lock_mask,
    output logic [NSEC-1:0]   addr_sel
);
    localparam int SEC_W   = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int QTR_LO  = NSEC - NSEC / 4;
    localparam int HALF_LO = NSEC - NSEC / 2;

    logic [SEC_W-1:0] sec_idx;
    assign sec_idx = addr[ADDR_W-1 -: SEC_W];

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        always_comb begin
            case (prot_lvl)
                2'b01:   lock_mask[s] = (s >= QTR_LO);
                2'b10:   lock_mask[s] = (s >= HALF_LO);
                2'b11:   lock_mask[s] = 1'b1;
                default: lock_mask[s] = 1'b0;
            endcase
            addr_sel[s] = (sec_idx == SEC_W'(s));
        end
    end
endmodule

// File: rtl/wpu_decide.sv
module wpu_decide
    import wpu_pkg::*;
#(
    parameter int NSEC = 4
) (
    input  req_kind_e       kind,
    input  logic            busy,
    input  logic            wel,
    input  logic            hw_lock,
    input  logic            pend,
    input  logic [NSEC-1:0] lock_mask,
    input  logic [NSEC-1:0] addr_sel,
    output logic            allow,
    output logic [NSEC-1:0] sel
);
    logic base_ok;
    assign base_ok = wel & ~busy;

    always_comb begin
        allow = 1'b0;
        sel   = '0;
        unique case (kind)
            REQ_PROG, REQ_SECT: begin
                allow = base_ok & ~|(addr_sel & lock_mask);
                sel   = addr_sel;
            end
            REQ_CHIP: begin
                allow = base_ok & ~&lock_mask;
                sel   = ~lock_mask;
            end
            REQ_STAT: begin
                allow = base_ok & pend & ~hw_lock;
                sel   = '0;
            end
            default: ;
        endcase
        if (!allow) sel = '0;
    end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
    import wpu_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         NSEC     = 4,
    parameter logic [7:0] RESET_SR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_load,
    input  logic [7:0]        sr_data,
    input  logic              cycle_done,
    input  logic              wr_busy,
    input  logic              lock_pin_n,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              frame_end,
    output logic              allow,
    output logic              grant,
    output logic [NSEC-1:0]   grant_sel,
    output logic [7:0]        status_byte
);
    typedef struct packed {
        logic            pin_en;
        logic [1:0]      prot_lvl;
        logic            wel;
        logic            pend;
        logic [2:0]      pend_bits;
        logic            pin_q;
        logic            grant;
        logic [NSEC-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    logic [NSEC-1:0] lock_mask, addr_sel, dec_sel;
    logic            hw_lock, pin_fell;
    req_kind_e       kind;

    assign kind     = req_kind_e'(req_kind);
    assign hw_lock  = st_q.pin_en & ~lock_pin_n;
    assign pin_fell = st_q.pin_q & ~lock_pin_n;

    wpu_sector_lock #(.ADDR_W(ADDR_W), .NSEC(NSEC)) i_lock (
        .prot_lvl  (st_q.prot_lvl),
        .addr      (req_addr),
        .lock_mask (lock_mask),
        .addr_sel  (addr_sel)
    );

    wpu_decide #(.NSEC(NSEC)) i_decide (
        .kind      (kind),
        .busy      (wr_busy),
        .wel       (st_q.wel),
        .hw_lock   (hw_lock),
        .pend      (st_q.pend),
        .lock_mask (lock_mask),
        .addr_sel  (addr_sel),
        .allow     (allow),
        .sel       (dec_sel)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.sel   = '0;
        st_d.pin_q = lock_pin_n;
        if (!wr_busy) begin
            if (clr_wel)      st_d.wel = 1'b0;
            else if (set_wel) st_d.wel = 1'b1;
            if (sr_load) begin
                st_d.pend      = 1'b1;
                st_d.pend_bits = {sr_data[SR_PIN_EN_BIT],
                                  sr_data[SR_LVL_HI_BIT],
                                  sr_data[SR_LVL_LO_BIT]};
            end
        end
        if (st_q.pend && st_q.pin_en && pin_fell) st_d.pend = 1'b0;
        if (frame_end) begin
            st_d.pend = 1'b0;
            if (allow) begin
                st_d.grant = 1'b1;
                st_d.sel   = dec_sel;
                if (kind == REQ_STAT) begin
                    st_d.pin_en   = st_q.pend_bits[2];
                    st_d.prot_lvl = st_q.pend_bits[1:0];
                end
            end
        end
        if (cycle_done) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pin_en   <= RESET_SR[SR_PIN_EN_BIT];
            st_q.prot_lvl <= {RESET_SR[SR_LVL_HI_BIT], RESET_SR[SR_LVL_LO_BIT]};
            st_q.pin_q    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant       = st_q.grant;
    assign grant_sel   = st_q.sel;
    assign status_byte = wr_busy ? 8'hFF
                       : {st_q.pin_en, 3'b000, st_q.prot_lvl, st_q.wel, 1'b0};
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker
    import wpu_pkg::*;
#(
    parameter int NSEC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_busy,
    input logic            lock_pin_n,
    input logic            cycle_done,
    input logic            frame_end,
    input logic [1:0]      req_kind,
    input logic            grant,
    input logic [NSEC-1:0] grant_sel,
    input logic [7:0]      status_byte
);
    a_r1_idle_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_busy |-> (status_byte[6:4] == 3'b000 && status_byte[0] == 1'b0));

    a_r2_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> status_byte == 8'hFF);

    a_r3_no_wel_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !wr_busy && !status_byte[SR_WEL_BIT]) |=> !grant);

    a_r4_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (wr_busy || !status_byte[SR_WEL_BIT]));

    a_r5_single_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && (req_kind == REQ_PROG || req_kind == REQ_SECT)) |=>
            (!grant || $countones(grant_sel) == 1));

    a_r7_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && req_kind == REQ_STAT && !wr_busy && !lock_pin_n
         && status_byte[SR_PIN_EN_BIT]) |=> !grant);

    a_r10_busy_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && wr_busy) |=> !grant);

    a_r11_grant_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(frame_end));
endmodule

bind wp_status_unit wpu_checker #(.NSEC(NSEC)) i_wpu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_busy     (wr_busy),
    .lock_pin_n  (lock_pin_n),
    .cycle_done  (cycle_done),
    .frame_end   (frame_end),
    .req_kind    (req_kind),
    .grant       (grant),
    .grant_sel   (grant_sel),
    .status_byte (status_byte)
);

// File: tb/test_wp_status_unit.sv
module test_wp_status_unit;
    localparam int ADDR_W = 17;
    localparam int NSEC   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_wel = 0, clr_wel = 0, sr_load = 0, cycle_done = 0;
    logic [7:0]        sr_data = '0;
    logic              wr_busy = 0, lock_pin_n = 1, frame_end = 0;
    logic [1:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              allow, grant;
    logic [NSEC-1:0]   grant_sel;
    logic [7:0]        status_byte;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wp_status_unit #(.ADDR_W(ADDR_W), .NSEC(NSEC), .RESET_SR(8'h00)) i_wp_status_unit (
        .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_load(sr_load), .sr_data(sr_data), .cycle_done(cycle_done),
        .wr_busy(wr_busy), .lock_pin_n(lock_pin_n), .req_kind(req_kind),
        .req_addr(req_addr), .frame_end(frame_end), .allow(allow),
        .grant(grant), .grant_sel(grant_sel), .status_byte(status_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic do_wren(); set_wel = 1; tick(); set_wel = 0; endtask
    task automatic do_wrdi(); clr_wel = 1; tick(); clr_wel = 0; endtask
    task automatic do_done(); cycle_done = 1; tick(); cycle_done = 0; endtask
    task automatic do_load(input logic [7:0] d);
        sr_data = d; sr_load = 1; tick(); sr_load = 0;
    endtask
    task automatic do_req(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                          output logic g, output logic [NSEC-1:0] s);
        req_kind = k; req_addr = a; frame_end = 1;
        tick();
        frame_end = 0;
        g = grant; s = grant_sel;
    endtask
    task automatic set_sr(input logic [7:0] d, output logic g);
        logic [NSEC-1:0] s;
        do_wren(); do_load(d); do_req(2'd3, '0, g, s); do_done();
    endtask

    task automatic t_reset();
        logic g; logic [NSEC-1:0] s;
        chk("R3 reset status", status_byte, 8'h00);
        do_req(2'd0, 17'h00000, g, s);
        chk("R3 program without latch", g, 1'b0);
    endtask

    task automatic t_latch();
        logic g; logic [NSEC-1:0] s;
        do_wren();
        chk("R1 R3 latch set status", status_byte, 8'h02);
        do_req(2'd0, 17'h00010, g, s);
        chk("R11 program grant", g, 1'b1);
        chk("R5 program sel", s, 4'b0001);
        tick();
        chk("R11 grant one cycle", grant, 1'b0);
        do_done();
        chk("R4 done clears latch", status_byte, 8'h00);
    endtask

    task automatic t_busy();
        logic g; logic [NSEC-1:0] s;
        wr_busy = 1; tick();
        chk("R2 busy status", status_byte, 8'hFF);
        do_wren();
        do_req(2'd0, 17'h0, g, s);
        chk("R10 busy request denied", g, 1'b0);
        wr_busy = 0; tick();
        chk("R10 wren ignored while busy", status_byte, 8'h00);
        do_wren(); wr_busy = 1; do_wrdi(); wr_busy = 0; tick();
        chk("R10 wrdi ignored while busy", status_byte, 8'h02);
        do_wrdi();
    endtask

    task automatic t_levels();
        logic g; logic [NSEC-1:0] s;
        set_sr(8'b0111_0110, g);
        chk("R8 status write grant", g, 1'b1);
        chk("R8 only kept bits", status_byte, 8'h04);
        do_wren();
        do_req(2'd0, 17'h18000, g, s);
        chk("R5 level1 top quarter locked", g, 1'b0);
        do_req(2'd0, 17'h17FFF, g, s);
        chk("R5 level1 below boundary", {g, s}, {1'b1, 4'b0100});
        do_done();
        set_sr(8'h08, g);
        chk("R1 level2 status", status_byte, 8'h08);
        do_wren();
        do_req(2'd1, 17'h10000, g, s);
        chk("R5 level2 sector erase locked", g, 1'b0);
        do_req(2'd1, 17'h0FFFF, g, s);
        chk("R5 level2 sector erase open", {g, s}, {1'b1, 4'b0010});
        do_req(2'd2, 17'h0, g, s);
        chk("R6 chip erase level2", {g, s}, {1'b1, 4'b0011});
        do_done();
        set_sr(8'h0C, g);
        do_wren();
        do_req(2'd2, 17'h0, g, s);
        chk("R6 chip erase level3 denied", g, 1'b0);
        do_req(2'd0, 17'h00000, g, s);
        chk("R5 level3 bottom locked", g, 1'b0);
        do_wrdi();
        set_sr(8'h00, g);
        chk("R5 levels cleared", status_byte, 8'h00);
    endtask

    task automatic t_hw();
        logic g; logic [NSEC-1:0] s;
        set_sr(8'h80, g);
        chk("R1 pin enable stored", status_byte, 8'h80);
        lock_pin_n = 0; tick();
        do_wren(); do_load(8'h00); do_req(2'd3, '0, g, s);
        chk("R7 locked status write denied", g, 1'b0);
        chk("R7 status unchanged", status_byte, 8'h82);
        do_wrdi();
        chk("R4 wrdi with pin low", status_byte, 8'h80);
        lock_pin_n = 1; tick();
        do_wren(); do_load(8'h00); do_req(2'd3, '0, g, s);
        chk("R7 pin high allows write", g, 1'b1);
        chk("R11 bits update at grant", status_byte, 8'h02);
        do_done();
        lock_pin_n = 0; tick();
        set_sr(8'h04, g);
        chk("R7 pin enable 0 ignores pin", status_byte, 8'h04);
        set_sr(8'h00, g);
        lock_pin_n = 1; tick();
    endtask

    task automatic t_cancel();
        logic g; logic [NSEC-1:0] s;
        set_sr(8'h80, g);
        do_wren(); do_load(8'h84);
        lock_pin_n = 0; tick(); lock_pin_n = 1; tick();
        do_req(2'd3, '0, g, s);
        chk("R9 cancelled write denied", g, 1'b0);
        chk("R9 status kept", status_byte, 8'h82);
        do_load(8'h84); do_req(2'd3, '0, g, s);
        chk("R9 clean write granted", g, 1'b1);
        do_done();
        chk("R9 clean write result", status_byte, 8'h84);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_latch();
        t_busy();
        t_levels();
        t_hw();
        t_cancel();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule